// File: doc/BRIEF.md
# Parallel Recursive Turbo Encoder

This block turns a block of information bits into a rate-1/5 coded stream using two identical 8-state recursive systematic convolutional encoders. The first encoder reads the block in natural order. The second reads it in scrambled order. The block does not compute the scrambling itself. It presents each step index on a permutation address port, and an external source answers in the same cycle with the buffer position to read.

A block is loaded bit by bit through a valid/ready input. The block length is sampled with the first bit. Once the last bit is stored, the input closes. The block then emits one five-bit output word per information bit through a valid/ready output. Six termination words follow, three for each encoder. During termination an encoder's input is taken from its own feedback, which clears its three state registers.

After the last termination word a one-cycle done pulse marks the end of the block, and the input opens again for the next block.

Top module: `pccc_encoder`

## Requirements
- R1: After reset, inReady is 1, outValid is 0 and done is 0.
- R2: Exactly blockLen bits are accepted per block. inReady and outValid are never high together, and inValid/inBit have no effect while inReady is low.
- R3: For data step k (0-based), permAddr equals k and outSys equals the k-th accepted bit.
- R4: The first encoder has states d1,d2,d3 (d1 most recent). Its feedback is a = u^d2^d3. It outputs outPar1A = a^d1^d3 and outPar1B = a^d1^d2^d3, and after each transfer its state becomes (a,d1,d2). Its input u is the natural-order bit.
- R5: The second encoder uses the same code and supplies outPar2A and outPar2B. Its input is the buffered bit at position permIdx.
- R6: After the data steps come three termination words for the first encoder. In each, u = d2^d3, outSys = u, outPar1A and outPar1B follow R4, and outPar2A = outPar2B = 0.
- R7: Three termination words for the second encoder come next. In each, outSys is its feedback-derived input, outPar2A and outPar2B are its parities, and outPar1A = outPar1B = 0. A block therefore yields blockLen+6 words.
- R8: Both encoders are in the all-zero state at the start of every block, including a block that directly follows another.
- R9: While outValid is high and outReady is low, all five output bits and permAddr hold their values into the next cycle.
- R10: done is high for exactly one cycle, the cycle after the last termination word transfers. inReady is high in that same cycle.
- R11: blockLen (40 to 256) is sampled when the first bit of a block is accepted. Changes to it later in the block are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| blockLen | input | 9 | Number of information bits in the next block |
| inValid | input | 1 | Input bit is valid |
| inBit | input | 1 | Information bit |
| inReady | output | 1 | Block accepts an input bit |
| permAddr | output | 8 | Step index sent to the permutation source |
| permIdx | input | 8 | Buffer position for the second encoder, same cycle |
| outValid | output | 1 | Output word is valid |
| outReady | input | 1 | Consumer takes the output word |
| outSys | output | 1 | Systematic or termination bit |
| outPar1A | output | 1 | First encoder parity A |
| outPar1B | output | 1 | First encoder parity B |
| outPar2A | output | 1 | Second encoder parity A |
| outPar2B | output | 1 | Second encoder parity B |
| done | output | 1 | One-cycle end-of-block pulse |

## Verification
The assertions rely on three conditions at the inputs. blockLen stays between 40 and 256 whenever a bit is offered. permIdx is a pure function of permAddr while a block drains, so a stalled word can be required to hold. permIdx always points inside the current block. The bench derives permIdx combinationally from permAddr with a fixed affine map reduced modulo the sampled length, and it changes blockLen only to in-range values. A length change in mid-block is kept within range for the same reason.

// File: rtl/pccc_enc_pkg.sv
package pccc_enc_pkg;

  // Memory of each constituent code (three delay stages, eight states)
  localparam int unsigned RSC_MEM = 3;

  typedef enum logic [1:0] {
    PH_LOAD  = 2'd0,
    PH_DATA  = 2'd1,
    PH_TAIL1 = 2'd2,
    PH_TAIL2 = 2'd3
  } phase_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    phase_e phase;
    logic   wrEn;
    logic   stepEn;
    logic   clrState;
  } ctl_t;

endpackage

// File: rtl/pccc_rsc_core.sv
module pccc_rsc_core
  import pccc_enc_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic adv,
  input  logic term,
  input  logic dIn,
  output logic sysBit,
  output logic parA,
  output logic parB,
  output logic isZero
);

  // st[0] = newest delay stage, st[RSC_MEM-1] = oldest
  logic [RSC_MEM-1:0] st;
  logic uSel;
  logic fbBit;

  always_comb begin
    uSel   = term ? (st[1] ^ st[2]) : dIn;
    fbBit  = uSel ^ st[1] ^ st[2];
    sysBit = uSel;
    parA   = fbBit ^ st[0] ^ st[2];
    parB   = fbBit ^ st[0] ^ st[1] ^ st[2];
    isZero = (st == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      st <= '0;
    end else if (adv) begin
      st <= {st[RSC_MEM-2:0], fbBit};
    end
  end

endmodule

// File: rtl/pccc_enc_ctrl.sv
module pccc_enc_ctrl
  import pccc_enc_pkg::*;
#(
  parameter int unsigned MAX_LEN    = 256,
  parameter int unsigned TAIL_STEPS = RSC_MEM,
  parameter int unsigned LEN_W      = $clog2(MAX_LEN + 1),
  parameter int unsigned IDX_W      = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LEN_W-1:0] blockLen,
  input  logic             inValid,
  input  logic             outReady,
  output logic             inReady,
  output logic             outValid,
  output logic             done,
  output ctl_t             ctl,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] rdIdx
);

  localparam logic [LEN_W-1:0] TAIL_LAST = LEN_W'(TAIL_STEPS - 1);

  phase_e            phase;
  logic [LEN_W-1:0]  cnt;
  logic [LEN_W-1:0]  lenReg;
  logic [LEN_W-1:0]  effLen;
  logic              inXfer;
  logic              outXfer;
  logic              lastIn;
  logic              lastData;
  logic              lastTail;

  always_comb begin
    inReady  = (phase == PH_LOAD);
    outValid = (phase != PH_LOAD);
    inXfer   = inReady && inValid;
    outXfer  = outValid && outReady;
    effLen   = (cnt == '0) ? blockLen : lenReg;
    lastIn   = (cnt == effLen - LEN_W'(1));
    lastData = (cnt == lenReg - LEN_W'(1));
    lastTail = (cnt == TAIL_LAST);
    wrIdx    = cnt[IDX_W-1:0];
    rdIdx    = cnt[IDX_W-1:0];
    ctl.phase    = phase;
    ctl.wrEn     = inXfer;
    ctl.stepEn   = outXfer;
    ctl.clrState = (phase == PH_LOAD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_LOAD;
      cnt    <= '0;
      lenReg <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_LOAD: begin
          if (inXfer) begin
            if (cnt == '0) lenReg <= blockLen;
            if (lastIn) begin
              phase <= PH_DATA;
              cnt   <= '0;
            end else begin
              cnt <= cnt + LEN_W'(1);
            end
          end
        end
        PH_DATA: begin
          if (outXfer) begin
            if (lastData) begin
              phase <= PH_TAIL1;
              cnt   <= '0;
            end else begin
              cnt <= cnt + LEN_W'(1);
            end
          end
        end
        PH_TAIL1: begin
          if (outXfer) begin
            if (lastTail) begin
              phase <= PH_TAIL2;
              cnt   <= '0;
            end else begin
              cnt <= cnt + LEN_W'(1);
            end
          end
        end
        PH_TAIL2: begin
          if (outXfer) begin
            if (lastTail) begin
              phase <= PH_LOAD;
              cnt   <= '0;
              done  <= 1'b1;
            end else begin
              cnt <= cnt + LEN_W'(1);
            end
          end
        end
        default: phase <= PH_LOAD;
      endcase
    end
  end

endmodule

// File: rtl/pccc_enc_dp.sv
module pccc_enc_dp
  import pccc_enc_pkg::*;
#(
  parameter int unsigned MAX_LEN  = 256,
  parameter int unsigned IDX_W    = $clog2(MAX_LEN),
  parameter int unsigned NUM_ENC  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctl_t               ctl,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic               inBit,
  input  logic [IDX_W-1:0]   rdIdx,
  input  logic [IDX_W-1:0]   permIdx,
  output logic               outSys,
  output logic               outPar1A,
  output logic               outPar1B,
  output logic               outPar2A,
  output logic               outPar2B,
  output logic [NUM_ENC-1:0] encZero
);

  logic [MAX_LEN-1:0] bitBuf;
  logic [NUM_ENC-1:0] encIn;
  logic [NUM_ENC-1:0] encTerm;
  logic [NUM_ENC-1:0] encAdv;
  logic [NUM_ENC-1:0] encSys;
  logic [NUM_ENC-1:0] encPA;
  logic [NUM_ENC-1:0] encPB;
  logic               inData;

  always_ff @(posedge clk) begin
    if (ctl.wrEn) bitBuf[wrIdx] <= inBit;
  end

  always_comb begin
    inData     = (ctl.phase == PH_DATA);
    encIn[0]   = bitBuf[rdIdx];
    encIn[1]   = bitBuf[permIdx];
    encTerm[0] = (ctl.phase == PH_TAIL1);
    encTerm[1] = (ctl.phase == PH_TAIL2);
    encAdv[0]  = ctl.stepEn && (inData || encTerm[0]);
    encAdv[1]  = ctl.stepEn && (inData || encTerm[1]);
  end

  for (genvar g = 0; g < NUM_ENC; g++) begin : g_enc
    pccc_rsc_core u_core (
      .clk    (clk),
      .rstN   (rstN),
      .clr    (ctl.clrState),
      .adv    (encAdv[g]),
      .term   (encTerm[g]),
      .dIn    (encIn[g]),
      .sysBit (encSys[g]),
      .parA   (encPA[g]),
      .parB   (encPB[g]),
      .isZero (encZero[g])
    );
  end

  always_comb begin
    outSys   = 1'b0;
    outPar1A = 1'b0;
    outPar1B = 1'b0;
    outPar2A = 1'b0;
    outPar2B = 1'b0;
    unique case (ctl.phase)
      PH_DATA: begin
        outSys   = encSys[0];
        outPar1A = encPA[0];
        outPar1B = encPB[0];
        outPar2A = encPA[1];
        outPar2B = encPB[1];
      end
      PH_TAIL1: begin
        outSys   = encSys[0];
        outPar1A = encPA[0];
        outPar1B = encPB[0];
      end
      PH_TAIL2: begin
        outSys   = encSys[1];
        outPar2A = encPA[1];
        outPar2B = encPB[1];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pccc_encoder.sv
module pccc_encoder
  import pccc_enc_pkg::*;
#(
  parameter int unsigned MAX_LEN = 256,
  parameter int unsigned LEN_W   = $clog2(MAX_LEN + 1),
  parameter int unsigned IDX_W   = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LEN_W-1:0] blockLen,
  input  logic             inValid,
  input  logic             inBit,
  output logic             inReady,
  output logic [IDX_W-1:0] permAddr,
  input  logic [IDX_W-1:0] permIdx,
  output logic             outValid,
  input  logic             outReady,
  output logic             outSys,
  output logic             outPar1A,
  output logic             outPar1B,
  output logic             outPar2A,
  output logic             outPar2B,
  output logic             done
);

  localparam int unsigned NUM_ENC = 2;

  ctl_t               ctl;
  logic [IDX_W-1:0]   wrIdx;
  logic [IDX_W-1:0]   rdIdx;
  logic [NUM_ENC-1:0] encZero;

  assign permAddr = rdIdx;

  pccc_enc_ctrl #(
    .MAX_LEN    (MAX_LEN),
    .TAIL_STEPS (RSC_MEM),
    .LEN_W      (LEN_W),
    .IDX_W      (IDX_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .blockLen (blockLen),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .done     (done),
    .ctl      (ctl),
    .wrIdx    (wrIdx),
    .rdIdx    (rdIdx)
  );

  pccc_enc_dp #(
    .MAX_LEN (MAX_LEN),
    .IDX_W   (IDX_W),
    .NUM_ENC (NUM_ENC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .wrIdx    (wrIdx),
    .inBit    (inBit),
    .rdIdx    (rdIdx),
    .permIdx  (permIdx),
    .outSys   (outSys),
    .outPar1A (outPar1A),
    .outPar1B (outPar1B),
    .outPar2A (outPar2A),
    .outPar2B (outPar2B),
    .encZero  (encZero)
  );

endmodule

// File: rtl/pccc_encoder_chk.sv
module pccc_encoder_chk #(
  parameter int unsigned MIN_LEN = 40,
  parameter int unsigned MAX_LEN = 256,
  parameter int unsigned LEN_W   = 9,
  parameter int unsigned IDX_W   = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [LEN_W-1:0] blockLen,
  input logic             inValid,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [4:0]       outWord,
  input logic [IDX_W-1:0] permAddr,
  input logic             done,
  input logic [1:0]       encZero
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (inReady && !outValid && !done));

  // R2
  io_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outWord) && $stable(permAddr)));

  // R10
  done_after_xfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(outValid && outReady) && inReady));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  zero_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (encZero == 2'b11));

  // R11
  len_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && inValid) |-> (blockLen >= LEN_W'(MIN_LEN) && blockLen <= LEN_W'(MAX_LEN)));

endmodule

bind pccc_encoder pccc_encoder_chk #(
  .MAX_LEN (MAX_LEN),
  .LEN_W   (LEN_W),
  .IDX_W   (IDX_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .blockLen (blockLen),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outWord  ({outSys, outPar1A, outPar1B, outPar2A, outPar2B}),
  .permAddr (permAddr),
  .done     (done),
  .encZero  (encZero)
);

// File: tb/pccc_encoder_tb_top.sv
`timescale 1ns/1ps
module pccc_encoder_tb_top;

  localparam int MAX_LEN = 256;
  localparam int LEN_W   = 9;
  localparam int IDX_W   = 8;

  logic             clk = 1'b0;
  logic             rstN;
  logic [LEN_W-1:0] blockLen;
  logic             inValid;
  logic             inBit;
  logic             inReady;
  logic [IDX_W-1:0] permAddr;
  logic [IDX_W-1:0] permIdx;
  logic             outValid;
  logic             outReady;
  logic             outSys, outPar1A, outPar1B, outPar2A, outPar2B;
  logic             done;

  always #4 clk = ~clk;

  int curLen = 40;
  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always_comb permIdx = IDX_W'((int'(permAddr) * 13 + 5) % curLen);

  pccc_encoder #(.MAX_LEN(MAX_LEN)) dut_i (
    .clk(clk), .rstN(rstN), .blockLen(blockLen), .inValid(inValid), .inBit(inBit),
    .inReady(inReady), .permAddr(permAddr), .permIdx(permIdx), .outValid(outValid),
    .outReady(outReady), .outSys(outSys), .outPar1A(outPar1A), .outPar1B(outPar1B),
    .outPar2A(outPar2A), .outPar2B(outPar2B), .done(done)
  );

  logic       blk[$];
  logic [4:0] expq[$];

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
      report();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Behavioural model of one constituent step (R4 code, R6/R7 termination)
  task automatic rscStep(inout logic [2:0] st, input logic u, input logic term,
                         output logic x, output logic pa, output logic pb);
    logic uu, a;
    uu = term ? (st[1] ^ st[2]) : u;
    a  = uu ^ st[1] ^ st[2];
    pa = a ^ st[0] ^ st[2];
    pb = a ^ st[0] ^ st[1] ^ st[2];
    x  = uu;
    st = {st[1:0], a};
  endtask

  task automatic buildExpected(input int n);
    logic [2:0] s1, s2;
    logic x, a0, a1, xd, b0, b1;
    s1 = 3'b000;
    s2 = 3'b000;
    expq.delete();
    for (int k = 0; k < n; k++) begin
      rscStep(s1, blk[k], 1'b0, x, a0, a1);
      rscStep(s2, blk[(k * 13 + 5) % n], 1'b0, xd, b0, b1);
      expq.push_back({x, a0, a1, b0, b1});
    end
    for (int t = 0; t < 3; t++) begin
      rscStep(s1, 1'b0, 1'b1, x, a0, a1);
      expq.push_back({x, a0, a1, 1'b0, 1'b0});
    end
    for (int t = 0; t < 3; t++) begin
      rscStep(s2, 1'b0, 1'b1, xd, b0, b1);
      expq.push_back({xd, 1'b0, 1'b0, b0, b1});
    end
  endtask

  task automatic runBlock(input int n, input int lenAfter, input int pat, input bit stall);
    int sent, it, got;
    bit holdValid;
    logic [4:0] holdWord, word;
    curLen = n;
    blk.delete();
    for (int k = 0; k < n; k++) begin
      case (pat)
        0: blk.push_back(1'($urandom % 2));
        1: blk.push_back(1'(k % 2));
        2: blk.push_back(1'b1);
        default: blk.push_back(1'((k % 3) == 0));
      endcase
    end
    buildExpected(n);
    blockLen = LEN_W'(n);
    sent = 0;
    it = 0;
    while (sent < n) begin
      @(negedge clk);
      if (sent >= 1) blockLen = LEN_W'(lenAfter);   // R11: later changes ignored
      if (stall && (it % 4 == 3)) begin
        inValid = 1'b0;
      end else begin
        inValid = 1'b1;
        inBit   = blk[sent];
      end
      it++;
      #1;
      if (inValid && inReady) sent++;
    end
    @(negedge clk);
    inValid = 1'b1;              // R2: offered while closed, must be ignored
    inBit   = 1'b1;
    #1;
    chk(inReady == 1'b0 && outValid == 1'b1, "R2 input closed after blockLen bits",
        {inReady, outValid}, 2'b01);
    got = 0;
    it = 0;
    holdValid = 1'b0;
    while (got < n + 6) begin
      @(negedge clk);
      outReady = stall ? ((it % 3) != 1) : 1'b1;
      it++;
      #1;
      word = {outSys, outPar1A, outPar1B, outPar2A, outPar2B};
      if (holdValid) chk(word == holdWord, "R9 stalled word held", word, holdWord);
      holdValid = 1'b0;
      if (!outValid) begin
        chk(1'b0, "R7 outValid during drain", outValid, 1);
      end else if (outReady) begin
        if (got < n) begin
          chk(permAddr == IDX_W'(got), "R3 permAddr step", permAddr, got);
          chk(word == expq[got], "R3 R4 R5 R8 data word", word, expq[got]);
        end else if (got < n + 3) begin
          chk(word == expq[got], "R6 first tail word", word, expq[got]);
        end else begin
          chk(word == expq[got], "R7 second tail word", word, expq[got]);
        end
        got++;
      end else begin
        holdWord  = word;
        holdValid = 1'b1;
      end
    end
    @(negedge clk);
    outReady = 1'b0;
    inValid  = 1'b0;
    #1;
    chk(done == 1'b1 && inReady == 1'b1, "R10 done with input reopened", {done, inReady}, 2'b11);
    @(negedge clk);
    #1;
    chk(done == 1'b0, "R10 done single cycle", done, 0);
  endtask

  initial begin
    rstN     = 1'b0;
    blockLen = LEN_W'(40);
    inValid  = 1'b0;
    inBit    = 1'b0;
    outReady = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk(inReady == 1'b1 && outValid == 1'b0 && done == 1'b0, "R1 reset state",
        {inReady, outValid, done}, 3'b100);
    runBlock(40, 40, 0, 1'b0);
    runBlock(100, 200, 1, 1'b1);   // R11 length changed in mid-block
    runBlock(256, 256, 2, 1'b0);
    runBlock(57, 41, 3, 1'b1);     // R11 shorter value after start
    runBlock(73, 73, 0, 1'b1);
    report();
    $finish;
  end

endmodule